// File: doc/BRIEF.md
# Debug Session Arm and Breakpoint Control

This block is the control register and session sequencer of an on-chip debug unit. Software writes one 8-bit control register to arm a debug session, to force an immediate trace trigger, to enable a breakpoint, to choose where that breakpoint goes and to pick which comparator bank is visible. The block tracks the session through an idle state, a first armed state and a tracing state. It ends the session on the final-state indication from the comparator logic, on trace completion, or on a software abort.

At the end of a session the block optionally raises a one-cycle breakpoint request. The request goes to background debug mode or to a software interrupt, according to a control bit and to whether background debug is enabled. It falls back to a software interrupt when background debug is unavailable. The bank-select field also drives one-hot selects that decide which comparator register bank shows in the 8-byte window and which status register shows at the single status offset.

The control field positions are fixed because software decodes them: bit 7 arm, bit 6 immediate trigger, bit 4 breakpoint-to-background-debug, bit 3 breakpoint enable, and bits 1:0 bank select. Bits 5 and 2 are unused.

Top module: `dbg_session_ctl`

## Requirements
- R1: After synchronous reset, the register reads 0x00, the sequencer state is idle (00), `armed_o`, `trig_req_o`, `brk_bdm_o` and `brk_swi_o` are 0, `cmp_win_sel_o` is 001 and `stat_sel_o` is 0001.
- R2: A write with bit 7 = 1 and bit 6 = 0 moves the sequencer to state 01 and sets `armed_o` from any state after the next edge. A write with bits 7 and 6 both 0 returns it to idle (00) and clears `armed_o`.
- R3: Readback shows `armed_o` in bit 7 and the written bits 4, 3, 1 and 0. Bits 6, 5 and 2 always read 0.
- R4: A write with bits 7 and 6 both 1 ends the session: the sequencer goes idle and disarmed, with no trigger and no breakpoint pulse.
- R5: A write with bit 7 = 0 and bit 6 = 1 in state 01, with the trace source enabled and secure mode off, gives a one-cycle `trig_req_o` pulse and enters the tracing state (10). For that write, bit 7 does not disarm.
- R6: Such a trigger write has no effect on state or `trig_req_o` when the trace source is disabled, when secure mode is on, when the sequencer is idle, or when tracing has already started.
- R7: `final_state_i` in state 01 with tracing allowed (trace source on, secure off) pulses `trig_req_o` and enters tracing (10). The breakpoint and disarm follow only on `trace_done_i`.
- R8: `final_state_i` in state 01 with tracing not allowed ends the session at once: the sequencer returns to idle, `armed_o` clears, and any breakpoint pulse shows after that same edge.
- R9: With bit 3 = 0, a session still ends and disarms, but neither breakpoint output pulses.
- R10: At session end with bit 3 = 1, the routing is as follows. Bit 4 = 1 with `bdm_en_i` = 1 pulses `brk_bdm_o`. `bdm_en_i` = 0 pulses `brk_swi_o` for either value of bit 4. Bit 4 = 0 with `bdm_en_i` = 1 pulses neither output.
- R11: Bank values 0, 1 and 2 select comparator bank 0, 1 or 2 (one-hot `cmp_win_sel_o`) and status register 0, 1 or 2 (`stat_sel_o` bit 0, 1 or 2). Value 3 selects no comparator bank and sets `stat_sel_o` to 1000 (the match-flag register).
- R12: `final_state_i` and `trace_done_i` are ignored while idle, and in any cycle that also has a register write the write takes priority over them.
- R13: Breakpoint requests and trigger requests last one cycle, and `brk_bdm_o` and `brk_swi_o` never assert together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register readback |
| final_state_i | input | 1 | Comparator logic reports the final state |
| trace_done_i | input | 1 | Trace buffer reports the session complete |
| trace_src_en_i | input | 1 | Trace source enabled |
| secure_i | input | 1 | Secure mode, tracing forbidden |
| bdm_en_i | input | 1 | Background debug mode enabled |
| armed_o | output | 1 | Session armed |
| seq_state_o | output | 2 | Sequencer state: 00 idle, 01 first state, 10 tracing |
| trig_req_o | output | 1 | One-cycle trace trigger request |
| brk_bdm_o | output | 1 | One-cycle breakpoint to background debug |
| brk_swi_o | output | 1 | One-cycle breakpoint to software interrupt |
| cmp_win_sel_o | output | 3 | One-hot comparator bank visible in the window |
| stat_sel_o | output | 4 | One-hot status register visible at the status offset |

## Verification
Directed runs end sessions three ways: through the final state with tracing allowed and then trace completion, through the final state with tracing blocked by a disabled source and by secure mode, and through an arm-plus-trigger abort. Comparing these separates immediate breakpoints from deferred ones. All four combinations of routing bit and background-debug enable are tried, and they separate the BDM path, the fallback to SWI and the silent case. Trigger writes are aimed at idle, armed, tracing, blocked-source and secure situations to separate an accepted trigger from an ignored one. A seeded random stream of writes and status inputs, with simultaneous write and final-state cycles, is checked cycle by cycle against a bench model built from the requirements.

// File: rtl/dbg_ctl_pkg.sv
package dbg_ctl_pkg;

    // Register geometry (field positions are decoded by software)
    localparam int CTL_W       = 8;
    localparam int POS_ARM     = 7;
    localparam int POS_TRIG    = 6;
    localparam int POS_TOBDM   = 4;
    localparam int POS_BRKEN   = 3;
    localparam int POS_BANK_LO = 0;
    localparam int BANK_W      = 2;
    localparam int NUM_CMP     = 3;
    localparam int STATE_W     = 2;

    typedef enum logic [STATE_W-1:0] {
        SEQ_IDLE   = 2'b00,
        SEQ_STATE1 = 2'b01,
        SEQ_TRACE  = 2'b10
    } seq_state_e;

    // Decoded write command, at most one field set per cycle
    typedef struct packed {
        logic arm_start;
        logic disarm;
        logic end_sess;
        logic trig;
    } ctl_cmd_t;

    // Stored configuration bits
    typedef struct packed {
        logic              to_bdm;
        logic              brk_en;
        logic [BANK_W-1:0] bank;
    } ctl_bits_t;

    typedef struct packed {
        logic bdm;
        logic swi;
    } brk_req_t;

    function automatic ctl_cmd_t decode_write(input logic wr,
                                              input logic arm_bit,
                                              input logic trig_bit);
        ctl_cmd_t c;
        c.end_sess  = wr &  arm_bit &  trig_bit;
        c.trig      = wr & ~arm_bit &  trig_bit;
        c.arm_start = wr &  arm_bit & ~trig_bit;
        c.disarm    = wr & ~arm_bit & ~trig_bit;
        return c;
    endfunction

    // Destination choice with fallback to software interrupt
    function automatic brk_req_t route_brk(input logic      fire,
                                           input ctl_bits_t b,
                                           input logic      bdm_en);
        brk_req_t r;
        r.bdm = fire & b.brk_en & b.to_bdm & bdm_en;
        r.swi = fire & b.brk_en & ~bdm_en;
        return r;
    endfunction

    function automatic logic [CTL_W-1:0] pack_readback(input logic      armed,
                                                       input ctl_bits_t b);
        logic [CTL_W-1:0] v;
        v = '0;
        v[POS_ARM]   = armed;
        v[POS_TOBDM] = b.to_bdm;
        v[POS_BRKEN] = b.brk_en;
        v[POS_BANK_LO +: BANK_W] = b.bank;
        return v;
    endfunction

endpackage

// File: rtl/dbg_ctl_regs.sv
module dbg_ctl_regs
    import dbg_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output ctl_cmd_t         cmd,
    output ctl_bits_t        bits
);

    ctl_bits_t bits_q;
    logic      unused_wbits;

    assign unused_wbits = ^{wdata[5], wdata[2]};

    // Arm and trigger are actions, not stored fields
    always_comb begin
        cmd = decode_write(wr, wdata[POS_ARM], wdata[POS_TRIG]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else if (wr) begin
            bits_q.to_bdm <= wdata[POS_TOBDM];
            bits_q.brk_en <= wdata[POS_BRKEN];
            bits_q.bank   <= wdata[POS_BANK_LO +: BANK_W];
        end
    end

    assign bits = bits_q;

endmodule

// File: rtl/dbg_ctl_seq.sv
module dbg_ctl_seq
    import dbg_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ctl_cmd_t   cmd,
    input  logic       final_i,
    input  logic       done_i,
    input  logic       trace_ok,
    output seq_state_e state,
    output logic       trig_pulse,
    output logic       sess_fire
);

    seq_state_e state_q, state_d;
    logic       trig_q, trig_d;

    always_comb begin
        state_d   = state_q;
        trig_d    = 1'b0;
        sess_fire = 1'b0;
        if (cmd.end_sess || cmd.disarm) begin
            state_d = SEQ_IDLE;
        end else if (cmd.arm_start) begin
            state_d = SEQ_STATE1;
        end else if (cmd.trig) begin
            // Accepted only before tracing and only when tracing may run
            if (state_q == SEQ_STATE1 && trace_ok) begin
                state_d = SEQ_TRACE;
                trig_d  = 1'b1;
            end
        end else begin
            case (state_q)
                SEQ_STATE1: begin
                    if (final_i) begin
                        if (trace_ok) begin
                            state_d = SEQ_TRACE;
                            trig_d  = 1'b1;
                        end else begin
                            state_d   = SEQ_IDLE;
                            sess_fire = 1'b1;
                        end
                    end
                end
                SEQ_TRACE: begin
                    if (done_i) begin
                        state_d   = SEQ_IDLE;
                        sess_fire = 1'b1;
                    end
                end
                SEQ_IDLE: state_d = SEQ_IDLE;
                default:  state_d = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            trig_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            trig_q  <= trig_d;
        end
    end

    assign state      = state_q;
    assign trig_pulse = trig_q;

endmodule

// File: rtl/dbg_ctl_route.sv
module dbg_ctl_route
    import dbg_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fire,
    input  ctl_bits_t bits,
    input  logic      bdm_en,
    output logic      brk_bdm,
    output logic      brk_swi
);

    brk_req_t req_d, req_q;

    always_comb begin
        req_d = route_brk(fire, bits, bdm_en);
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= req_d;
    end

    assign brk_bdm = req_q.bdm;
    assign brk_swi = req_q.swi;

endmodule

// File: rtl/dbg_ctl_window.sv
module dbg_ctl_window
    import dbg_ctl_pkg::*;
#(
    parameter int N_CMP = NUM_CMP
) (
    input  logic [BANK_W-1:0] bank,
    output logic [N_CMP-1:0]  cmp_sel,
    output logic [N_CMP:0]    stat_sel
);

    for (genvar i = 0; i < N_CMP; i++) begin : g_bank
        assign cmp_sel[i]  = (bank == BANK_W'(i));
        assign stat_sel[i] = cmp_sel[i];
    end

    // Any code beyond the comparator count shows the match-flag register
    assign stat_sel[N_CMP] = ~|cmp_sel;

endmodule

// File: rtl/dbg_session_ctl.sv
module dbg_session_ctl
    import dbg_ctl_pkg::*;
#(
    parameter int N_CMP = NUM_CMP
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [CTL_W-1:0]   reg_wdata,
    output logic [CTL_W-1:0]   reg_rdata,
    input  logic               final_state_i,
    input  logic               trace_done_i,
    input  logic               trace_src_en_i,
    input  logic               secure_i,
    input  logic               bdm_en_i,
    output logic               armed_o,
    output logic [STATE_W-1:0] seq_state_o,
    output logic               trig_req_o,
    output logic               brk_bdm_o,
    output logic               brk_swi_o,
    output logic [N_CMP-1:0]   cmp_win_sel_o,
    output logic [N_CMP:0]     stat_sel_o
);

    ctl_cmd_t   cmd;
    ctl_bits_t  bits;
    seq_state_e state;
    logic       fire;
    logic       trace_ok;

    assign trace_ok = trace_src_en_i & ~secure_i;

    dbg_ctl_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .cmd   (cmd),
        .bits  (bits)
    );

    dbg_ctl_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .final_i    (final_state_i),
        .done_i     (trace_done_i),
        .trace_ok   (trace_ok),
        .state      (state),
        .trig_pulse (trig_req_o),
        .sess_fire  (fire)
    );

    dbg_ctl_route u_route (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .bits    (bits),
        .bdm_en  (bdm_en_i),
        .brk_bdm (brk_bdm_o),
        .brk_swi (brk_swi_o)
    );

    dbg_ctl_window #(.N_CMP(N_CMP)) u_win (
        .bank     (bits.bank),
        .cmp_sel  (cmp_win_sel_o),
        .stat_sel (stat_sel_o)
    );

    assign armed_o     = (state != SEQ_IDLE);
    assign seq_state_o = state;
    assign reg_rdata   = pack_readback(armed_o, bits);

endmodule

// File: rtl/dbg_session_ctl_chk.sv
module dbg_session_ctl_chk #(
    parameter int N_CMP = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic [7:0]       reg_wdata,
    input logic             trace_src_en_i,
    input logic             secure_i,
    input logic             armed_o,
    input logic [1:0]       seq_state_o,
    input logic             trig_req_o,
    input logic             brk_bdm_o,
    input logic             brk_swi_o,
    input logic [N_CMP-1:0] cmp_win_sel_o,
    input logic [N_CMP:0]   stat_sel_o
);

    a_r2_arm_write: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata[7] && !reg_wdata[6]) |=> (armed_o && seq_state_o == 2'b01));

    a_r4_abort_write: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata[7] && reg_wdata[6]) |=>
            (!armed_o && seq_state_o == 2'b00 && !trig_req_o && !brk_bdm_o && !brk_swi_o));

    a_r6_trig_blocked: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_wdata[7] && reg_wdata[6] && (!trace_src_en_i || secure_i)) |=> !trig_req_o);

    a_r7_trig_enters_trace: assert property (@(posedge clk) disable iff (rst)
        trig_req_o |-> (seq_state_o == 2'b10));

    a_r8_brk_disarms: assert property (@(posedge clk) disable iff (rst)
        (brk_bdm_o || brk_swi_o) |-> !armed_o);

    a_r11_stat_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(stat_sel_o) == 1);

    a_r11_window_match: assert property (@(posedge clk) disable iff (rst)
        (cmp_win_sel_o == '0) == stat_sel_o[N_CMP]);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (seq_state_o == 2'b00 && !reg_wr) |=> (!trig_req_o && !brk_bdm_o && !brk_swi_o));

    a_r13_brk_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(brk_bdm_o && brk_swi_o));

    a_r13_bdm_pulse: assert property (@(posedge clk) disable iff (rst)
        brk_bdm_o |=> !brk_bdm_o);

    a_r13_swi_pulse: assert property (@(posedge clk) disable iff (rst)
        brk_swi_o |=> !brk_swi_o);

    a_r13_trig_pulse: assert property (@(posedge clk) disable iff (rst)
        trig_req_o |=> !trig_req_o);

endmodule

bind dbg_session_ctl dbg_session_ctl_chk #(.N_CMP(N_CMP)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .reg_wr         (reg_wr),
    .reg_wdata      (reg_wdata),
    .trace_src_en_i (trace_src_en_i),
    .secure_i       (secure_i),
    .armed_o        (armed_o),
    .seq_state_o    (seq_state_o),
    .trig_req_o     (trig_req_o),
    .brk_bdm_o      (brk_bdm_o),
    .brk_swi_o      (brk_swi_o),
    .cmp_win_sel_o  (cmp_win_sel_o),
    .stat_sel_o     (stat_sel_o)
);

// File: tb/dbg_session_ctl_test.sv
module dbg_session_ctl_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;
    localparam int N_RANDOM   = 3000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       final_state_i = 1'b0;
    logic       trace_done_i = 1'b0;
    logic       trace_src_en_i = 1'b0;
    logic       secure_i = 1'b0;
    logic       bdm_en_i = 1'b0;
    logic       armed_o;
    logic [1:0] seq_state_o;
    logic       trig_req_o;
    logic       brk_bdm_o;
    logic       brk_swi_o;
    logic [2:0] cmp_win_sel_o;
    logic [3:0] stat_sel_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 0;

    // Bench model, built from the requirements
    logic [1:0] m_state = 2'b00;
    logic       m_tobdm = 1'b0;
    logic       m_brken = 1'b0;
    logic [1:0] m_bank  = 2'b00;
    logic       m_trig  = 1'b0;
    logic       m_bdm   = 1'b0;
    logic       m_swi   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_session_ctl uut (
        .clk            (clk),
        .rst            (rst),
        .reg_wr         (reg_wr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .final_state_i  (final_state_i),
        .trace_done_i   (trace_done_i),
        .trace_src_en_i (trace_src_en_i),
        .secure_i       (secure_i),
        .bdm_en_i       (bdm_en_i),
        .armed_o        (armed_o),
        .seq_state_o    (seq_state_o),
        .trig_req_o     (trig_req_o),
        .brk_bdm_o      (brk_bdm_o),
        .brk_swi_o      (brk_swi_o),
        .cmp_win_sel_o  (cmp_win_sel_o),
        .stat_sel_o     (stat_sel_o)
    );

    function automatic logic [7:0] exp_rdata();
        return {(m_state != 2'b00), 2'b00, m_tobdm, m_brken, 1'b0, m_bank};
    endfunction

    function automatic logic [2:0] exp_cmp();
        return (m_bank == 2'd3) ? 3'b000 : (3'b001 << m_bank);
    endfunction

    function automatic logic [3:0] exp_stat();
        return (m_bank == 2'd3) ? 4'b1000 : (4'b0001 << m_bank);
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "state",    {6'd0, seq_state_o},   {6'd0, m_state});
        chk(tag, "armed",    {7'd0, armed_o},       {7'd0, (m_state != 2'b00)});
        chk(tag, "trig_req", {7'd0, trig_req_o},    {7'd0, m_trig});
        chk(tag, "brk_bdm",  {7'd0, brk_bdm_o},     {7'd0, m_bdm});
        chk(tag, "brk_swi",  {7'd0, brk_swi_o},     {7'd0, m_swi});
        chk(tag, "rdata",    reg_rdata,             exp_rdata());
        chk(tag, "cmp_win",  {5'd0, cmp_win_sel_o}, {5'd0, exp_cmp()});
        chk(tag, "stat_sel", {4'd0, stat_sel_o},    {4'd0, exp_stat()});
    endtask

    // One clock: drive at the falling edge, model the next state, compare at the next falling edge
    task automatic cycle(input string tag, input logic wr, input logic [7:0] wd,
                         input logic fin, input logic dn,
                         input logic src, input logic sec, input logic ben);
        logic       ok;
        logic       fire;
        logic [1:0] ns;
        reg_wr = wr; reg_wdata = wd; final_state_i = fin; trace_done_i = dn;
        trace_src_en_i = src; secure_i = sec; bdm_en_i = ben;
        ok = src & ~sec;
        fire = 1'b0;
        ns = m_state;
        m_trig = 1'b0;
        if (wr) begin
            if (wd[7] && wd[6])      ns = 2'b00;
            else if (wd[6]) begin
                if (m_state == 2'b01 && ok) begin ns = 2'b10; m_trig = 1'b1; end
            end
            else if (wd[7])          ns = 2'b01;
            else                     ns = 2'b00;
        end else if (m_state == 2'b01 && fin) begin
            if (ok) begin ns = 2'b10; m_trig = 1'b1; end
            else begin ns = 2'b00; fire = 1'b1; end
        end else if (m_state == 2'b10 && dn) begin
            ns = 2'b00; fire = 1'b1;
        end
        m_bdm = fire & m_brken & m_tobdm & ben;
        m_swi = fire & m_brken & ~ben;
        m_state = ns;
        if (wr) begin
            m_tobdm = wd[4]; m_brken = wd[3]; m_bank = wd[1:0];
        end
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all("R1");

        // R2 arm and disarm
        cycle("R2", 1, 8'h80, 0, 0, 1, 0, 0);
        cycle("R2", 1, 8'h00, 0, 0, 1, 0, 0);
        // R3 readback masking
        cycle("R3", 1, 8'h3F, 0, 0, 1, 0, 0);
        cycle("R3", 1, 8'h2C, 0, 0, 1, 0, 0);
        cycle("R3", 1, 8'hBB, 0, 0, 1, 0, 0);
        // R4 arm plus trigger aborts
        cycle("R4", 1, 8'h80, 0, 0, 1, 0, 0);
        cycle("R4", 1, 8'hC8, 0, 0, 1, 0, 0);
        // R5 trigger write accepted
        cycle("R5", 1, 8'h80, 0, 0, 1, 0, 0);
        cycle("R5", 1, 8'h40, 0, 0, 1, 0, 0);
        cycle("R5", 0, 8'h00, 0, 0, 1, 0, 0);
        // R6 trigger ignored: already tracing, source off, secure, idle
        cycle("R6", 1, 8'h40, 0, 0, 1, 0, 0);
        cycle("R6", 1, 8'h80, 0, 0, 1, 0, 0);
        cycle("R6", 1, 8'h40, 0, 0, 0, 0, 0);
        cycle("R6", 1, 8'h40, 0, 0, 1, 1, 0);
        cycle("R6", 1, 8'h00, 0, 0, 1, 0, 0);
        cycle("R6", 1, 8'h40, 0, 0, 1, 0, 0);
        // R7 final with tracing, breakpoint after trace done
        cycle("R7", 1, 8'h88, 0, 0, 1, 0, 0);
        cycle("R7", 0, 8'h00, 1, 0, 1, 0, 0);
        cycle("R7", 0, 8'h00, 0, 0, 1, 0, 0);
        cycle("R7", 0, 8'h00, 0, 1, 1, 0, 0);
        cycle("R7", 0, 8'h00, 0, 0, 1, 0, 0);
        // R8 final without tracing: immediate breakpoint
        cycle("R8", 1, 8'h88, 0, 0, 0, 0, 0);
        cycle("R8", 0, 8'h00, 1, 0, 0, 0, 0);
        cycle("R8", 1, 8'h88, 0, 0, 1, 1, 0);
        cycle("R8", 0, 8'h00, 1, 0, 1, 1, 0);
        // R9 breakpoint disabled
        cycle("R9", 1, 8'h90, 0, 0, 0, 0, 1);
        cycle("R9", 0, 8'h00, 1, 0, 0, 0, 1);
        cycle("R9", 1, 8'h80, 0, 0, 1, 0, 0);
        cycle("R9", 0, 8'h00, 1, 0, 1, 0, 0);
        cycle("R9", 0, 8'h00, 0, 1, 1, 0, 0);
        // R10 routing table
        cycle("R10", 1, 8'h98, 0, 0, 0, 0, 1);
        cycle("R10", 0, 8'h00, 1, 0, 0, 0, 1);
        cycle("R10", 1, 8'h98, 0, 0, 0, 0, 0);
        cycle("R10", 0, 8'h00, 1, 0, 0, 0, 0);
        cycle("R10", 1, 8'h88, 0, 0, 0, 0, 0);
        cycle("R10", 0, 8'h00, 1, 0, 0, 0, 0);
        cycle("R10", 1, 8'h88, 0, 0, 0, 0, 1);
        cycle("R10", 0, 8'h00, 1, 0, 0, 0, 1);
        // R11 bank selection
        for (int b = 0; b < 4; b++) cycle("R11", 1, 8'(b), 0, 0, 1, 0, 0);
        // R12 idle ignores status inputs; write wins over them
        cycle("R12", 1, 8'h08, 0, 0, 0, 0, 0);
        cycle("R12", 0, 8'h00, 1, 1, 0, 0, 0);
        cycle("R12", 1, 8'h88, 1, 0, 0, 0, 0);
        cycle("R12", 0, 8'h00, 1, 0, 1, 0, 0);
        cycle("R12", 1, 8'h88, 0, 1, 1, 0, 0);
        cycle("R12", 1, 8'h08, 1, 0, 0, 0, 0);

        // R13 random stream with model comparison
        for (int i = 0; i < N_RANDOM; i++) begin
            logic [7:0] wd;
            logic       wr;
            wd = 8'($urandom);
            wr = ($urandom % 5) == 0;
            cycle("R13", wr, wd, ($urandom % 6) == 0, ($urandom % 6) == 0,
                  ($urandom % 4) != 0, ($urandom % 5) == 0, ($urandom % 2) == 0);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule